// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and the local memory-mapped fabric of a root port. A request names a bus, device, function and register offset, together with a read/write flag and 32-bit write data. The block checks that the device number can exist on that bus. It then issues a single local access at a translated address and returns a read response.

Requests to bus 0 land in the local register window. Requests to any other bus land in a one-megabyte outbound window that occupies the last megabyte of the 16 MB I/O-based space. For those requests the block also programs a translation target value that carries bus, device and function, and picks the configuration transaction type. Bus 1 uses type 0 and buses above 1 use type 1. A read that is filtered out or aborted downstream completes with all-ones. A filtered write never reaches the fabric.

One cycle after reset the block programs its outbound region: enable bit, base and limit. It then takes one request at a time under valid/ready handshakes.

Top module: `cfgx_translator`

## Requirements
- R1: While reset is held, `req_ready` is 0 and `win_ctl2` is 0. After the first clock edge out of reset, `req_ready` is 1 and `win_ctl2` is 0x8000_0000 (bit 31 enables the region). `win_base` is 0x01F0_0000, `win_limit` is 0x01FF_C000, `cfg_type` is 4 and `cfg_target` is 0.
- R2: A request with device number above 1 on bus 0, or above 0 on bus 1, is rejected. No access is issued, and `cfg_type` and `cfg_target` keep their values. A rejected read responds with `rsp_rdata`=0xFFFF_FFFF and `rsp_err`=1. A rejected write responds with `rsp_rdata`=0 and `rsp_err`=1.
- R3: An accepted request on bus 0 or 1 sets `cfg_type` to 4 (type-0 configuration). An accepted request on any bus of 2 or above sets it to 5 (type-1 configuration).
- R4: The access address is 0x01FF_C000 plus the offset for bus 0, and 0x01F0_0000 plus the offset for any other bus. In both cases bits 1:0 of the offset are cleared first.
- R5: An accepted request on a nonzero bus sets `cfg_target` to bus in bits 31:24, device in bits 23:19 and function in bits 18:16, with all other bits 0. A bus 0 request leaves `cfg_target` unchanged.
- R6: For a read, the response carries `acc_rdata` with `rsp_err`=0. If `acc_abort` is 1 with `acc_done`, the response is instead 0xFFFF_FFFF with `rsp_err`=1.
- R7: For a write, the access carries `acc_write`=1 and the request's write data. The response has `rsp_rdata`=0, and `rsp_err` equals the `acc_abort` value seen with `acc_done`.
- R8: Only one request is in flight. `req_ready` is 0 from acceptance until the response is taken. The access outputs stay valid and stable until `acc_done`. The response stays valid and stable until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_offset | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| acc_valid | output | 1 | Local access pending |
| acc_write | output | 1 | Local access direction |
| acc_addr | output | 32 | Translated local address |
| acc_wdata | output | 32 | Local write data |
| acc_done | input | 1 | Local access completes this cycle |
| acc_abort | input | 1 | Local access aborted (with acc_done) |
| acc_rdata | input | 32 | Local read data (with acc_done) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read result |
| rsp_err | output | 1 | Rejected or aborted |
| cfg_type | output | 5 | Configuration transaction type code |
| cfg_target | output | 32 | Translation target value |
| win_base | output | 32 | Outbound region base |
| win_limit | output | 32 | Outbound region limit |
| win_ctl2 | output | 32 | Outbound region control word, bit 31 enable |

## Verification
The request table covers several kinds of traffic, and each tells a different fault apart:
- Bus 0 requests to devices 0 and 1 separate the local-window mapping from the outbound one.
- Bus 1 requests and requests on buses above 1 (including bus 255, device 31, function 7, offset 0xFFF) separate the type-0 from the type-1 choice and expose any misplaced target field.
- Unaligned offsets show whether the low bits are cleared.
- Rejected reads and writes on both bus 0 and bus 1 are checked for missing traffic and unchanged type and target.
- Aborted reads and writes separate the all-ones substitution from the error flag.

Directed runs stretch the access and response phases over several cycles to check that outputs are held, and they check the state during and after reset.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_ACC,
        ST_RSP
    } seq_state_e;

    localparam int unsigned TYPE_W      = 5;
    localparam int unsigned CTL2_W      = 32;
    localparam int unsigned CTL2_EN_BIT = 31;

    localparam logic [TYPE_W-1:0] TT_CFG0 = 5'd4;
    localparam logic [TYPE_W-1:0] TT_CFG1 = 5'd5;

endpackage

// File: rtl/cfgx_dev_filter.sv
module cfgx_dev_filter #(
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned DEV_W      = 5,
    parameter int unsigned MAX_DEV_B0 = 1,
    parameter int unsigned MAX_DEV_B1 = 0
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [DEV_W-1:0] dev_i,
    output logic             ok_o
);

    localparam logic [DEV_W-1:0] LIM_B0 = DEV_W'(MAX_DEV_B0);
    localparam logic [DEV_W-1:0] LIM_B1 = DEV_W'(MAX_DEV_B1);

    always_comb begin
        if (bus_i == BUS_W'(0)) begin
            ok_o = (dev_i <= LIM_B0);
        end else if (bus_i == BUS_W'(1)) begin
            ok_o = (dev_i <= LIM_B1);
        end else begin
            ok_o = 1'b1;
        end
    end

endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
    import cfgx_pkg::*;
#(
    parameter int unsigned       BUS_W      = 8,
    parameter int unsigned       DEV_W      = 5,
    parameter int unsigned       FN_W       = 3,
    parameter int unsigned       OFS_W      = 12,
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       TGT_W      = 32,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] IO_BASE    = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] SPACE_SIZE = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] WIN_SLOT   = 32'h0010_0000
) (
    input  logic [BUS_W-1:0]  bus_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [OFS_W-1:0]  off_i,
    output logic              local_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [TGT_W-1:0]  tgt_o
);

    localparam logic [ADDR_W-1:0] CFG_BASE = IO_BASE + SPACE_SIZE - WIN_SLOT;
    localparam int unsigned FN_LSB  = 16;
    localparam int unsigned DEV_LSB = FN_LSB + FN_W;
    localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;

    logic [OFS_W-1:0] off_aligned;

    always_comb begin
        off_aligned = off_i & ~OFS_W'(3);
        local_o     = (bus_i == BUS_W'(0));
        addr_o      = (local_o ? LOCAL_BASE : CFG_BASE) + ADDR_W'(off_aligned);
        type_o      = (bus_i < BUS_W'(2)) ? TT_CFG0 : TT_CFG1;
    end

    generate
        if (BUS_LSB + BUS_W <= TGT_W) begin : g_tgt_fit
            always_comb begin
                tgt_o = '0;
                tgt_o[BUS_LSB +: BUS_W] = bus_i;
                tgt_o[DEV_LSB +: DEV_W] = dev_i;
                tgt_o[FN_LSB  +: FN_W]  = fn_i;
            end
        end else begin : g_tgt_trunc
            logic [BUS_LSB+BUS_W-1:0] wide;
            always_comb begin
                wide = '0;
                wide[BUS_LSB +: BUS_W] = bus_i;
                wide[DEV_LSB +: DEV_W] = dev_i;
                wide[FN_LSB  +: FN_W]  = fn_i;
                tgt_o = wide[TGT_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TGT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              route_ok,
    input  logic              map_local,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [TYPE_W-1:0] map_type,
    input  logic [TGT_W-1:0]  map_tgt,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_done,
    input  logic              acc_abort,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [TYPE_W-1:0] cfg_type,
    output logic [TGT_W-1:0]  cfg_target,
    output logic [CTL2_W-1:0] win_ctl2
);

    typedef struct packed {
        seq_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic [TYPE_W-1:0] ttype;
        logic [TGT_W-1:0]  tgt;
        logic [CTL2_W-1:0] ctl2;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_INIT: begin
                r_d.ctl2              = '0;
                r_d.ctl2[CTL2_EN_BIT] = 1'b1;
                r_d.ttype             = TT_CFG0;
                r_d.tgt               = '0;
                r_d.state             = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.write = req_write;
                    if (route_ok) begin
                        r_d.addr  = map_addr;
                        r_d.wdata = req_wdata;
                        r_d.ttype = map_type;
                        if (!map_local) begin
                            r_d.tgt = map_tgt;
                        end
                        r_d.state = ST_ACC;
                    end else begin
                        r_d.rdata = req_write ? '0 : '1;
                        r_d.err   = 1'b1;
                        r_d.state = ST_RSP;
                    end
                end
            end
            ST_ACC: begin
                if (acc_done) begin
                    r_d.err = acc_abort;
                    if (r_q.write) begin
                        r_d.rdata = '0;
                    end else if (acc_abort) begin
                        r_d.rdata = '1;
                    end else begin
                        r_d.rdata = acc_rdata;
                    end
                    r_d.state = ST_RSP;
                end
            end
            ST_RSP: begin
                if (rsp_ready) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == ST_IDLE);
    assign acc_valid  = (r_q.state == ST_ACC);
    assign acc_write  = r_q.write;
    assign acc_addr   = r_q.addr;
    assign acc_wdata  = r_q.wdata;
    assign rsp_valid  = (r_q.state == ST_RSP);
    assign rsp_rdata  = r_q.rdata;
    assign rsp_err    = r_q.err;
    assign cfg_type   = r_q.ttype;
    assign cfg_target = r_q.tgt;
    assign win_ctl2   = r_q.ctl2;

    // R8: access held until completion
    a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_done |=> acc_valid && $stable(acc_addr) && $stable(acc_wdata));

    // R8: response held until taken
    a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

    // R8: at most one phase active
    a_r8_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, acc_valid, rsp_valid}));

    // R2: filtered request goes straight to an error response
    a_r2_reject_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !route_ok |=> rsp_valid && rsp_err && !acc_valid
            && $stable(cfg_type) && $stable(cfg_target));

    // R6: aborted read completes with all-ones
    a_r6_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_done && acc_abort && !acc_write |=> rsp_valid && rsp_err && (rsp_rdata == '1));

    // R5: bus 0 leaves the translation target alone
    a_r5_local_keeps_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && map_local |=> $stable(cfg_target));

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
    import cfgx_pkg::*;
#(
    parameter int unsigned        BUS_W      = 8,
    parameter int unsigned        DEV_W      = 5,
    parameter int unsigned        FN_W       = 3,
    parameter int unsigned        OFS_W      = 12,
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        DATA_W     = 32,
    parameter logic [ADDR_W-1:0]  LOCAL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0]  IO_BASE    = 32'h0100_0000,
    parameter logic [ADDR_W-1:0]  SPACE_SIZE = 32'h0100_0000,
    parameter logic [ADDR_W-1:0]  WIN_SLOT   = 32'h0010_0000,
    parameter logic [ADDR_W-1:0]  WIN_SIZE   = 32'h000F_C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_func,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_done,
    input  logic              acc_abort,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [TYPE_W-1:0] cfg_type,
    output logic [31:0]       cfg_target,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_limit,
    output logic [CTL2_W-1:0] win_ctl2
);

    localparam int unsigned       TGT_W    = 32;
    localparam logic [ADDR_W-1:0] CFG_BASE = IO_BASE + SPACE_SIZE - WIN_SLOT;

    logic              route_ok;
    logic              map_local;
    logic [ADDR_W-1:0] map_addr;
    logic [TYPE_W-1:0] map_type;
    logic [TGT_W-1:0]  map_tgt;

    cfgx_dev_filter #(
        .BUS_W (BUS_W),
        .DEV_W (DEV_W)
    ) u_filter (
        .bus_i (req_bus),
        .dev_i (req_dev),
        .ok_o  (route_ok)
    );

    cfgx_addr_map #(
        .BUS_W      (BUS_W),
        .DEV_W      (DEV_W),
        .FN_W       (FN_W),
        .OFS_W      (OFS_W),
        .ADDR_W     (ADDR_W),
        .TGT_W      (TGT_W),
        .LOCAL_BASE (LOCAL_BASE),
        .IO_BASE    (IO_BASE),
        .SPACE_SIZE (SPACE_SIZE),
        .WIN_SLOT   (WIN_SLOT)
    ) u_map (
        .bus_i   (req_bus),
        .dev_i   (req_dev),
        .fn_i    (req_func),
        .off_i   (req_offset),
        .local_o (map_local),
        .addr_o  (map_addr),
        .type_o  (map_type),
        .tgt_o   (map_tgt)
    );

    cfgx_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TGT_W  (TGT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .route_ok   (route_ok),
        .map_local  (map_local),
        .map_addr   (map_addr),
        .map_type   (map_type),
        .map_tgt    (map_tgt),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_done   (acc_done),
        .acc_abort  (acc_abort),
        .acc_rdata  (acc_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .cfg_type   (cfg_type),
        .cfg_target (cfg_target),
        .win_ctl2   (win_ctl2)
    );

    assign win_base  = CFG_BASE;
    assign win_limit = CFG_BASE + WIN_SIZE;

endmodule

// File: tb/cfgx_translator_test.sv
module cfgx_translator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic        wr;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
        logic [31:0] wdata;
        logic        abort;
        logic [31:0] mdata;
        logic        iss;
        logic [31:0] eaddr;
        logic [4:0]  etype;
        logic [31:0] etgt;
        logic [31:0] erd;
        logic        eerr;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd0,   5'd0,  3'd0, 12'h010, 32'h0,         1'b0, 32'h1111_2222, 1'b1, 32'h01FF_C010, 5'd4, 32'h0000_0000, 32'h1111_2222, 1'b0},
        '{1'b0, 8'd0,   5'd1,  3'd0, 12'h103, 32'h0,         1'b0, 32'hA5A5_0001, 1'b1, 32'h01FF_C100, 5'd4, 32'h0000_0000, 32'hA5A5_0001, 1'b0},
        '{1'b0, 8'd0,   5'd2,  3'd0, 12'h000, 32'h0,         1'b0, 32'h0,         1'b0, 32'h0,         5'd4, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
        '{1'b0, 8'd1,   5'd0,  3'd3, 12'h008, 32'h0,         1'b0, 32'hDEAD_BEEF, 1'b1, 32'h01F0_0008, 5'd4, 32'h0103_0000, 32'hDEAD_BEEF, 1'b0},
        '{1'b1, 8'd1,   5'd1,  3'd0, 12'h000, 32'h5555_5555, 1'b0, 32'h0,         1'b0, 32'h0,         5'd4, 32'h0103_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 8'd2,   5'd5,  3'd1, 12'h0FE, 32'h0,         1'b1, 32'h1234_0000, 1'b1, 32'h01F0_00FC, 5'd5, 32'h0229_0000, 32'hFFFF_FFFF, 1'b1},
        '{1'b1, 8'd0,   5'd0,  3'd0, 12'h004, 32'h1234_5678, 1'b0, 32'h0,         1'b1, 32'h01FF_C004, 5'd4, 32'h0229_0000, 32'h0000_0000, 1'b0},
        '{1'b1, 8'd255, 5'd31, 3'd7, 12'hFFF, 32'hCAFE_F00D, 1'b0, 32'h0,         1'b1, 32'h01F0_0FFC, 5'd5, 32'hFFFF_0000, 32'h0000_0000, 1'b0},
        '{1'b1, 8'd3,   5'd0,  3'd0, 12'h000, 32'h0F0F_0F0F, 1'b1, 32'h0,         1'b1, 32'h01F0_0000, 5'd5, 32'h0300_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 8'd1,   5'd0,  3'd0, 12'h3FC, 32'h0,         1'b0, 32'h0BAD_CAFE, 1'b1, 32'h01F0_03FC, 5'd4, 32'h0100_0000, 32'h0BAD_CAFE, 1'b0},
        '{1'b0, 8'd0,   5'd31, 3'd0, 12'h000, 32'h0,         1'b0, 32'h0,         1'b0, 32'h0,         5'd4, 32'h0100_0000, 32'hFFFF_FFFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        acc_valid;
    logic        acc_write;
    logic [31:0] acc_addr;
    logic [31:0] acc_wdata;
    logic        acc_done = 1'b0;
    logic        acc_abort = 1'b0;
    logic [31:0] acc_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [4:0]  cfg_type;
    logic [31:0] cfg_target;
    logic [31:0] win_base;
    logic [31:0] win_limit;
    logic [31:0] win_ctl2;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgx_translator uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_bus    (req_bus),
        .req_dev    (req_dev),
        .req_func   (req_func),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_done   (acc_done),
        .acc_abort  (acc_abort),
        .acc_rdata  (acc_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .cfg_type   (cfg_type),
        .cfg_target (cfg_target),
        .win_base   (win_base),
        .win_limit  (win_limit),
        .win_ctl2   (win_ctl2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit seen_acc = 1'b0;
        bit finished = 1'b0;
        @(negedge clk);
        req_write = v.wr; req_bus = v.bus; req_dev = v.dev; req_func = v.fn;
        req_offset = v.off; req_wdata = v.wdata; req_valid = 1'b1;
        chk($sformatf("R8 v%0d ready before accept", idx), 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 50 && !finished; g++) begin
            if (acc_valid) begin
                seen_acc = 1'b1;
                chk($sformatf("R4 v%0d addr", idx), acc_addr, v.eaddr);
                chk($sformatf("R3 v%0d type", idx), 32'(cfg_type), 32'(v.etype));
                chk($sformatf("R5 v%0d target", idx), cfg_target, v.etgt);
                chk($sformatf("R7 v%0d write flag", idx), 32'(acc_write), 32'(v.wr));
                if (v.wr) chk($sformatf("R7 v%0d wdata", idx), acc_wdata, v.wdata);
                acc_done = 1'b1; acc_abort = v.abort; acc_rdata = v.mdata;
                @(posedge clk);
                @(negedge clk);
                acc_done = 1'b0; acc_abort = 1'b0; acc_rdata = '0;
            end else if (rsp_valid) begin
                chk($sformatf("R2 v%0d issued", idx), 32'(seen_acc), 32'(v.iss));
                chk($sformatf("R6 v%0d rdata", idx), rsp_rdata, v.erd);
                chk($sformatf("R7 v%0d err", idx), 32'(rsp_err), 32'(v.eerr));
                rsp_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                rsp_ready = 1'b0;
                finished = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        chk($sformatf("R8 v%0d completed", idx), 32'(finished), 32'd1);
        chk($sformatf("R2 v%0d held type", idx), 32'(cfg_type), 32'(v.etype));
        chk($sformatf("R5 v%0d held target", idx), cfg_target, v.etgt);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk("R1 ready in reset", 32'(req_ready), 32'd0);
        chk("R1 ctl2 in reset", win_ctl2, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: region programmed after first edge
        chk("R1 ready after init", 32'(req_ready), 32'd1);
        chk("R1 ctl2 enable", win_ctl2, 32'h8000_0000);
        chk("R1 base", win_base, 32'h01F0_0000);
        chk("R1 limit", win_limit, 32'h01FF_C000);
        chk("R1 type", 32'(cfg_type), 32'd4);
        chk("R1 target", cfg_target, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R8: stretched access and response phases
        @(negedge clk);
        req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd0; req_func = 3'd0;
        req_offset = 12'h020; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 acc held valid", 32'(acc_valid), 32'd1);
            chk("R8 acc held addr", acc_addr, 32'h01FF_C020);
            chk("R8 busy not ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        acc_done = 1'b1; acc_rdata = 32'h7777_8888;
        @(posedge clk);
        @(negedge clk);
        acc_done = 1'b0; acc_rdata = '0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 rsp held valid", 32'(rsp_valid), 32'd1);
            chk("R6 rsp held data", rsp_rdata, 32'h7777_8888);
            chk("R8 rsp busy not ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 idle after response", 32'(req_ready), 32'd1);
        chk("R8 no rsp after take", 32'(rsp_valid), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule